// File: doc/BRIEF.md
# Contactless Type-A Cascade Select Sequencer

This block runs the reader side of the cascade select phase for a 13.56 MHz type-A card. It takes the anticollision field of the card's request answer and decides first whether a standard select is possible at all. It then works through up to three cascade levels. At each level it sends a select-all command, settles any bit collisions by sending bit-oriented select commands with a growing partial UID, and then sends a full select that carries a block check byte and CRC_A. It reads the select acknowledge byte (SAK) to decide whether another level follows.

Frames leave on a transmit handshake as a packed bit vector with a bit count. Replies come back on a one-cycle receive strobe, together with a collision flag and a collision bit position. The sequencer also tells the receiver at which bit offset inside the first byte the reply must start. While it runs, it assembles the card UID (4, 7 or 10 bytes) and ends with a one-cycle done pulse and a two-bit result code. When the UID is already known, the select-all and collision steps can be skipped.

Top module: `csel_seq`

## Requirements
- R1: If `atqa_frame[4:0]` is zero when `start` is taken, `done` rises on the next cycle with `result`=3 and no frame is offered.
- R2: In anticollision mode each level opens with a 16-bit frame: byte0 = select code 0x93+2·level (0x93, 0x95, 0x97), byte1 = 0x20. Frame byte k sits at `tx_data[8k+7:8k]`, and bit 0 is sent first.
- R3: A full select is a 72-bit frame with these bytes in order: select code, 0x70, UID0..UID3, BCC (the XOR of UID0..UID3), CRC_A low byte, CRC_A high byte. CRC_A is computed over the first 7 bytes with the reflected polynomial 0x8408, preset 0x6363 and no final inversion.
- R4: On a collision at position p, the known UID bits below p are kept, bit p is forced to 1, and k = p+1 bits are known. The next frame has 16+k bits: select code, NVB = ((2+k/8)<<4)|(k mod 8), then the known UID bits from UID bit 0 upward, with all higher bits zero.
- R5: For a reply to a select-all or bit-oriented select, `rx_offset` equals k mod 8. `rx_data` bit j carries UID bit 8·⌊k/8⌋+j, and bits below the offset are ignored. Resolution repeats until a reply arrives without a collision; UID bits 0..31 of that reply are then used.
- R6: If SAK bit 2 is set, UID bytes 1..3 of the level (the cascade tag is dropped) are appended to `uid` and the next level begins. Otherwise UID bytes 0..3 are appended and the run ends. UID byte n is at `uid[8n+7:8n]`, and `uid_len` counts the bytes.
- R7: At the end, `result` is 1 if the final SAK bit 5 is set and 2 if it is clear. `sak` holds the last SAK.
- R8: With `use_known`=1 no select-all is sent. A level below `known_levels`-1 sends the full select with UID bytes 0x88, K[3L], K[3L+1], K[3L+2]. The final level sends K[3L]..K[3L+3], where K[n] is `known_uid[8n+7:8n]`.
- R9: If no reply arrives within `timeout_limit` cycles after a frame is accepted, the run ends with `result`=0 and `uid_len`=0.
- R10: If SAK bit 2 is set at the third level, the run ends with `result`=0 and `uid_len`=0.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_nbits` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a select run (taken when idle) |
| atqa_frame | input | 5 | Anticollision field, bits 4:0 of the first request-answer byte |
| use_known | input | 1 | Select with a supplied UID instead of anticollision |
| known_uid | input | 80 | Supplied UID, byte n at bits 8n+7:8n |
| known_levels | input | 3 | Cascade levels of the supplied UID (1 to 3) |
| timeout_limit | input | 16 | Reply wait limit in cycles |
| tx_valid | output | 1 | Frame offered to transmitter |
| tx_ready | input | 1 | Transmitter accepts frame |
| tx_data | output | 72 | Frame bits, byte k at bits 8k+7:8k |
| tx_nbits | output | 7 | Number of frame bits to send |
| rx_offset | output | 3 | Bit offset where the next reply starts |
| rx_valid | input | 1 | Reply strobe |
| rx_data | input | 40 | Reply bits |
| rx_coll | input | 1 | Reply had a bit collision |
| rx_coll_pos | input | 6 | Collision bit index in `rx_data` |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 fail, 1 success, 2 no layer-4, 3 proprietary |
| sak | output | 8 | Last select acknowledge |
| uid | output | 80 | Assembled UID |
| uid_len | output | 4 | UID length in bytes |

## Verification
The cases cover a single-size UID with no collision, a double-size UID whose cascade tag must be dropped, and a triple-size UID supplied directly. Together they tell apart the three select codes, the 3-byte and 4-byte append paths, and the select-all and known-UID frame sources. A two-step collision run places the second collision past the first byte boundary. This separates the NVB byte count from the bit count and shows whether the reply shift uses the whole-byte base or the raw bit count, and garbage below the receive offset shows whether those bits leak in. A card with a proprietary field, a silent card, a cascade bit at the last level and a slow transmitter exercise the early exit, timeout, overflow and hold behaviour.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int RXW     = 40;   // UID bits plus BCC in a reply
  localparam int KW      = 6;    // width of a known-bit count
  localparam int FRAME_W = 72;   // longest frame: full select
  localparam int NB_W    = 7;

  localparam logic [7:0] SEL_BASE = 8'h93;
  localparam logic [7:0] NVB_ALL  = 8'h20;
  localparam logic [7:0] NVB_FULL = 8'h70;
  localparam logic [7:0] CASC_TAG = 8'h88;
  localparam int SAK_MORE = 2;
  localparam int SAK_L4   = 5;

  localparam logic [1:0] RES_FAIL  = 2'd0;
  localparam logic [1:0] RES_OK    = 2'd1;
  localparam logic [1:0] RES_NO_L4 = 2'd2;
  localparam logic [1:0] RES_PROP  = 2'd3;

  typedef enum logic [2:0] {ST_IDLE, ST_LVL, ST_BUILD, ST_TX, ST_RX} csel_st_t;
endpackage

// File: rtl/csel_crc_a.sv
module csel_crc_a #(
  parameter int NBYTES = 7
) (
  input  logic [8*NBYTES-1:0] data,
  output logic [15:0]         crc
);
  always_comb begin
    logic [15:0] c;
    c = 16'h6363;
    for (int b = 0; b < NBYTES; b++) begin
      c = c ^ {8'h00, data[8*b +: 8]};
      for (int i = 0; i < 8; i++) begin
        c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
      end
    end
    crc = c;
  end
endmodule

// File: rtl/csel_merge.sv
module csel_merge
  import csel_pkg::*;
(
  input  logic [RXW-1:0] acc,
  input  logic [KW-1:0]  known,
  input  logic [RXW-1:0] rx,
  input  logic           coll,
  input  logic [KW-1:0]  pos,
  output logic [RXW-1:0] merged,
  output logic [KW-1:0]  new_known
);
  logic [KW-1:0]  base;
  logic [KW-1:0]  limit;
  logic [RXW-1:0] shifted;

  always_comb begin
    base    = {known[KW-1:3], 3'b000};
    shifted = rx << base;
    limit   = coll ? KW'(base + pos) : KW'(RXW);
    for (int m = 0; m < RXW; m++) begin
      merged[m] = acc[m];
      if (KW'(m) >= known && KW'(m) < limit) merged[m] = shifted[m];
      if (coll && KW'(m) == limit) merged[m] = 1'b1;
    end
    new_known = limit + 1'b1;
  end
endmodule

// File: rtl/csel_timer.sv
module csel_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/csel_seq.sv
module csel_seq
  import csel_pkg::*;
#(
  parameter int TMO_W  = 16,
  parameter int LEVELS = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [4:0]                   atqa_frame,
  input  logic                         use_known,
  input  logic [8*(3*LEVELS+1)-1:0]    known_uid,
  input  logic [$clog2(LEVELS):0]      known_levels,
  input  logic [TMO_W-1:0]             timeout_limit,
  output logic                         tx_valid,
  input  logic                         tx_ready,
  output logic [FRAME_W-1:0]           tx_data,
  output logic [NB_W-1:0]              tx_nbits,
  output logic [2:0]                   rx_offset,
  input  logic                         rx_valid,
  input  logic [RXW-1:0]               rx_data,
  input  logic                         rx_coll,
  input  logic [KW-1:0]                rx_coll_pos,
  output logic                         done,
  output logic [1:0]                   result,
  output logic [7:0]                   sak,
  output logic [8*(3*LEVELS+1)-1:0]    uid,
  output logic [$clog2(3*LEVELS+2)-1:0] uid_len
);
  localparam int UID_BYTES = 3*LEVELS + 1;
  localparam int LVL_W     = $clog2(LEVELS);

  csel_st_t               st;
  logic [LVL_W-1:0]       level;
  logic [KW-1:0]          known;
  logic [RXW-1:0]         acc;
  logic                   ph_sak;
  logic                   known_q;
  logic [LVL_W:0]         levels_q;
  logic [TMO_W-1:0]       tmo_q;

  logic [7:0]             sel;
  logic [7:0]             bcc;
  logic [15:0]            crc;
  logic [RXW-1:0]         merged;
  logic [KW-1:0]          new_known;
  logic [7:0]             coll_nvb;
  logic                   expired;

  assign sel      = SEL_BASE + {level, 1'b0};
  assign bcc      = acc[7:0] ^ acc[15:8] ^ acc[23:16] ^ acc[31:24];
  assign coll_nvb = {4'(4'd2 + new_known[KW-1:3]), 1'b0, new_known[2:0]};

  csel_crc_a #(.NBYTES(7)) u_crc (
    .data ({bcc, acc[31:0], NVB_FULL, sel}),
    .crc  (crc)
  );

  csel_merge u_merge (
    .acc       (acc),
    .known     (known),
    .rx        (rx_data),
    .coll      (rx_coll),
    .pos       (rx_coll_pos),
    .merged    (merged),
    .new_known (new_known)
  );

  csel_timer #(.W(TMO_W)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .run     (st == ST_RX),
    .limit   (tmo_q),
    .expired (expired)
  );

  // UID word sent at a level when the UID is supplied
  function automatic logic [31:0] known_word(input logic [LVL_W-1:0] lv);
    if ({1'b0, lv} < levels_q - 1'b1) return {known_uid[lv*24 +: 24], CASC_TAG};
    else                             return known_uid[lv*24 +: 32];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      level     <= '0;
      known     <= '0;
      acc       <= '0;
      ph_sak    <= 1'b0;
      known_q   <= 1'b0;
      levels_q  <= '0;
      tmo_q     <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      tx_nbits  <= '0;
      rx_offset <= '0;
      done      <= 1'b0;
      result    <= RES_FAIL;
      sak       <= '0;
      uid       <= '0;
      uid_len   <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          known_q  <= use_known;
          levels_q <= known_levels;
          tmo_q    <= timeout_limit;
          level    <= '0;
          uid      <= '0;
          uid_len  <= '0;
          if (atqa_frame == 5'd0) begin
            done   <= 1'b1;
            result <= RES_PROP;
          end else begin
            st <= ST_LVL;
          end
        end
        ST_LVL: begin
          if (known_q) begin
            acc <= {8'h00, known_word(level)};
            st  <= ST_BUILD;
          end else begin
            acc       <= '0;
            known     <= '0;
            tx_data   <= {56'b0, NVB_ALL, sel};
            tx_nbits  <= NB_W'(16);
            rx_offset <= 3'd0;
            ph_sak    <= 1'b0;
            tx_valid  <= 1'b1;
            st        <= ST_TX;
          end
        end
        ST_BUILD: begin
          tx_data   <= {crc, bcc, acc[31:0], NVB_FULL, sel};
          tx_nbits  <= NB_W'(FRAME_W);
          rx_offset <= 3'd0;
          ph_sak    <= 1'b1;
          tx_valid  <= 1'b1;
          st        <= ST_TX;
        end
        ST_TX: if (tx_ready) begin
          tx_valid <= 1'b0;
          st       <= ST_RX;
        end
        ST_RX: begin
          if (rx_valid && !ph_sak) begin
            acc <= merged;
            if (rx_coll) begin
              known     <= new_known;
              tx_data   <= {16'b0, merged, coll_nvb, sel};
              tx_nbits  <= NB_W'(16) + NB_W'(new_known);
              rx_offset <= new_known[2:0];
              tx_valid  <= 1'b1;
              st        <= ST_TX;
            end else begin
              st <= ST_BUILD;
            end
          end else if (rx_valid) begin
            sak <= rx_data[7:0];
            if (rx_data[SAK_MORE]) begin
              if (level == LVL_W'(LEVELS-1)) begin
                done    <= 1'b1;
                result  <= RES_FAIL;
                uid_len <= '0;
                st      <= ST_IDLE;
              end else begin
                uid[8*uid_len +: 24] <= acc[31:8];
                uid_len <= uid_len + 3'd3;
                level   <= level + 1'b1;
                st      <= ST_LVL;
              end
            end else begin
              uid[8*uid_len +: 32] <= acc[31:0];
              uid_len <= uid_len + 3'd4;
              done    <= 1'b1;
              result  <= rx_data[SAK_L4] ? RES_OK : RES_NO_L4;
              st      <= ST_IDLE;
            end
          end else if (expired) begin
            done    <= 1'b1;
            result  <= RES_FAIL;
            uid_len <= '0;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: proprietary field ends the run at once without a frame
  a_r1_proprietary: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start && atqa_frame == 5'd0) |=> (done && result == RES_PROP && !tx_valid));

  // R2: every frame starts with one of the level select codes
  a_r2_sel_code: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_data[7:0] == 8'h93 || tx_data[7:0] == 8'h95 || tx_data[7:0] == 8'h97));

  // R3: full select carries NVB 0x70 and a matching BCC
  a_r3_full_bcc: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_nbits == NB_W'(FRAME_W)) |->
      (tx_data[15:8] == NVB_FULL &&
       tx_data[55:48] == (tx_data[23:16] ^ tx_data[31:24] ^ tx_data[39:32] ^ tx_data[47:40])));

  // R4: short frames carry an NVB matching their bit count
  a_r4_nvb: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_nbits != NB_W'(FRAME_W)) |->
      (tx_data[15:12] == 4'((tx_nbits - NB_W'(16)) >> 3) + 4'd2 && tx_data[10:8] == tx_nbits[2:0]));

  // R5: receive offset matches known bits mod 8
  a_r5_offset: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_nbits != NB_W'(FRAME_W)) |-> (rx_offset == tx_nbits[2:0]));

  // R9/R10: a failed run leaves no UID
  a_r9_fail_clears: assert property (@(posedge clk) disable iff (rst)
    (done && result == RES_FAIL) |-> (uid_len == '0));

  // R6: UID length never passes the store size
  a_r6_len_bound: assert property (@(posedge clk) disable iff (rst)
    uid_len <= UID_BYTES);

  // R11: offered frame holds until accepted
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_nbits)));

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/sim_csel_seq.sv
module sim_csel_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  atqa_frame = 5'h04;
  logic        use_known = 1'b0;
  logic [79:0] known_uid = '0;
  logic [2:0]  known_levels = 3'd1;
  logic [15:0] timeout_limit = 16'd200;
  logic        tx_valid, tx_ready = 1'b0;
  logic [71:0] tx_data;
  logic [6:0]  tx_nbits;
  logic [2:0]  rx_offset;
  logic        rx_valid = 1'b0;
  logic [39:0] rx_data = '0;
  logic        rx_coll = 1'b0;
  logic [5:0]  rx_coll_pos = '0;
  logic        done;
  logic [1:0]  result;
  logic [7:0]  sak;
  logic [79:0] uid;
  logic [3:0]  uid_len;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  csel_seq u0 (
    .clk(clk), .rst(rst), .start(start), .atqa_frame(atqa_frame),
    .use_known(use_known), .known_uid(known_uid), .known_levels(known_levels),
    .timeout_limit(timeout_limit), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_nbits(tx_nbits), .rx_offset(rx_offset),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_coll(rx_coll),
    .rx_coll_pos(rx_coll_pos), .done(done), .result(result), .sak(sak),
    .uid(uid), .uid_len(uid_len)
  );

  task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_a(input logic [55:0] d);
    logic [15:0] c = 16'h6363;
    for (int b = 0; b < 7; b++) begin
      c ^= {8'h00, d[8*b +: 8]};
      for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [71:0] full_frame(input logic [7:0] sel, input logic [31:0] u);
    logic [7:0]  b = u[7:0] ^ u[15:8] ^ u[23:16] ^ u[31:24];
    logic [55:0] f = {b, u, 8'h70, sel};
    return {crc_a(f), f};
  endfunction

  // reply bit j lands on UID bit 8*(k/8)+j; keep bits below k; force 1 at collision
  function automatic logic [39:0] model_merge(input logic [39:0] acc, input int k,
      input logic [39:0] rx, input bit coll, input int pos, output int newk);
    int base = (k / 8) * 8;
    int lim  = coll ? base + pos : 40;
    logic [39:0] r = acc;
    for (int m = k; m < lim && m < 40; m++) r[m] = rx[m - base];
    if (coll && lim < 40) r[lim] = 1'b1;
    newk = lim + 1;
    return r;
  endfunction

  task automatic kick(input logic [4:0] aq, input bit kn, input logic [2:0] lv);
    @(negedge clk);
    atqa_frame = aq; use_known = kn; known_levels = lv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic take_frame(output logic [71:0] d, output logic [6:0] n,
                            output logic [2:0] off, input int delay);
    int w = 0;
    while (!tx_valid && w < 1000) begin @(negedge clk); w++; end
    d = tx_data; n = tx_nbits; off = rx_offset;
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      check(tx_valid && tx_data == d && tx_nbits == n, "R11 frame hold", {1'b0, tx_valid, tx_data}, {1'b1, d});
    end
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic reply(input logic [39:0] d, input bit c, input logic [5:0] p);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_coll = c; rx_coll_pos = p;
    @(negedge clk);
    rx_valid = 1'b0; rx_coll = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
    check(done, tag, {79'b0, done}, 80'h1);
  endtask

  task automatic t_reset;
    check(!tx_valid && !done && uid_len == 0, "R11 reset state", {tx_valid, done, uid_len}, 80'h0);
  endtask

  task automatic t_proprietary;
    kick(5'h00, 1'b0, 3'd1);
    check(done && result == 2'd3, "R1 proprietary result", {done, result}, {1'b1, 2'd3});
    repeat (5) @(negedge clk);
    check(!tx_valid, "R1 no frame", {79'b0, tx_valid}, 80'h0);
  endtask

  task automatic t_single;
    logic [71:0] d; logic [6:0] n; logic [2:0] o;
    logic [31:0] u = 32'hA1B2C3D4;
    kick(5'h04, 1'b0, 3'd1);
    take_frame(d, n, o, 3);
    check(n == 16 && d[15:0] == 16'h2093, "R2 select-all L1", {n, d}, {7'd16, 72'h2093});
    reply({u[7:0] ^ u[15:8] ^ u[23:16] ^ u[31:24], u}, 1'b0, 6'd0);
    take_frame(d, n, o, 0);
    check(n == 72 && d == full_frame(8'h93, u), "R3 full select", d, full_frame(8'h93, u));
    reply(40'h20, 1'b0, 6'd0);
    wait_done("R7 done single");
    check(result == 2'd1 && sak == 8'h20, "R7 result ok", {sak, result}, {8'h20, 2'd1});
    check(uid_len == 4 && uid[31:0] == u, "R6 single uid", {uid_len, uid[31:0]}, {4'd4, u});
  endtask

  task automatic t_double;
    logic [71:0] d; logic [6:0] n; logic [2:0] o;
    kick(5'h04, 1'b0, 3'd1);
    take_frame(d, n, o, 0);
    reply(40'h00_33_22_11_88, 1'b0, 6'd0);
    take_frame(d, n, o, 0);
    check(d == full_frame(8'h93, 32'h33221188), "R3 level1 select", d, full_frame(8'h93, 32'h33221188));
    reply(40'h04, 1'b0, 6'd0);
    take_frame(d, n, o, 0);
    check(n == 16 && d[15:0] == 16'h2095, "R2 select-all L2", {n, d}, {7'd16, 72'h2095});
    reply(40'h00_77_66_55_44, 1'b0, 6'd0);
    take_frame(d, n, o, 0);
    check(d == full_frame(8'h95, 32'h77665544), "R3 level2 select", d, full_frame(8'h95, 32'h77665544));
    reply(40'h00, 1'b0, 6'd0);
    wait_done("R7 done double");
    check(result == 2'd2, "R7 no layer4", {78'b0, result}, 80'd2);
    check(uid_len == 7 && uid[55:0] == 56'h77665544_332211, "R6 tag dropped", {uid_len, uid}, {4'd7, 56'h77665544332211});
  endtask

  task automatic t_known(input logic [7:0] last_sak, input logic [1:0] exp_res, input logic [3:0] exp_len);
    logic [71:0] d; logic [6:0] n; logic [2:0] o;
    known_uid = 80'hA9_A8_A7_A6_A5_A4_A3_A2_A1_A0;
    kick(5'h01, 1'b1, 3'd3);
    take_frame(d, n, o, 0);
    check(d == full_frame(8'h93, 32'hA2A1A0_88), "R8 known L1", d, full_frame(8'h93, 32'hA2A1A088));
    reply(40'h04, 1'b0, 6'd0);
    take_frame(d, n, o, 0);
    check(d == full_frame(8'h95, 32'hA5A4A3_88), "R8 known L2", d, full_frame(8'h95, 32'hA5A4A388));
    reply(40'h04, 1'b0, 6'd0);
    take_frame(d, n, o, 0);
    check(d == full_frame(8'h97, 32'hA9A8A7A6), "R8 known L3", d, full_frame(8'h97, 32'hA9A8A7A6));
    reply({32'h0, last_sak}, 1'b0, 6'd0);
    wait_done("R8 done known");
    check(result == exp_res && uid_len == exp_len, "R10 R8 known end", {uid_len, result}, {exp_len, exp_res});
    if (exp_len == 10) check(uid == known_uid, "R6 triple uid", uid, known_uid);
    use_known = 1'b0;
  endtask

  task automatic t_collision;
    logic [71:0] d; logic [6:0] n; logic [2:0] o;
    logic [39:0] a = 40'h55_66_77_88_9B, b = 40'hC3_5A_F0_0F_E7, c = 40'h3C_96_4B_D2_6E;
    logic [39:0] m1, m2, m3; int k1, k2, k3;
    kick(5'h04, 1'b0, 3'd1);
    take_frame(d, n, o, 0);
    reply(a, 1'b1, 6'd5);
    m1 = model_merge(40'h0, 0, a, 1'b1, 5, k1);
    take_frame(d, n, o, 0);
    check(n == 22 && d == {16'b0, m1, 8'h26, 8'h93}, "R4 first coll frame", d, {16'b0, m1, 8'h26, 8'h93});
    check(o == 3'd6, "R5 offset 6", {77'b0, o}, 80'd6);
    reply(b, 1'b1, 6'd12);
    m2 = model_merge(m1, k1, b, 1'b1, 12, k2);
    take_frame(d, n, o, 0);
    check(n == 29 && d == {16'b0, m2, 8'h35, 8'h93}, "R4 second coll frame", d, {16'b0, m2, 8'h35, 8'h93});
    check(o == 3'd5, "R5 offset 5", {77'b0, o}, 80'd5);
    reply(c, 1'b0, 6'd0);
    m3 = model_merge(m2, k2, c, 1'b0, 0, k3);
    take_frame(d, n, o, 0);
    check(d == full_frame(8'h93, m3[31:0]), "R5 resolved select", d, full_frame(8'h93, m3[31:0]));
    reply(40'h20, 1'b0, 6'd0);
    wait_done("R5 done coll");
    check(uid_len == 4 && uid[31:0] == m3[31:0], "R5 resolved uid", {uid_len, uid[31:0]}, {4'd4, m3[31:0]});
  endtask

  task automatic t_timeout;
    logic [71:0] d; logic [6:0] n; logic [2:0] o;
    timeout_limit = 16'd40;
    kick(5'h04, 1'b0, 3'd1);
    take_frame(d, n, o, 0);
    repeat (20) @(negedge clk);
    check(!done, "R9 no early abort", {79'b0, done}, 80'h0);
    wait_done("R9 timeout done");
    check(result == 2'd0 && uid_len == 0, "R9 timeout result", {uid_len, result}, 80'h0);
    timeout_limit = 16'd200;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_proprietary();
    t_single();
    t_double();
    t_known(8'h20, 2'd1, 4'd10);
    t_known(8'h04, 2'd0, 4'd0);
    t_collision();
    t_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule